// File: doc/BRIEF.md
# Survivor Path Pruning Unit

This unit follows the add-compare-select stage of a reduced-complexity soft-output Viterbi decoder. On every trellis step it receives the freshly computed metric of each of `NS` states, a flag per state that says whether that state still carries a live path, and the largest metric of the stage before. It returns a mask that marks the paths allowed to continue.

Two pruning rules run in a fixed order. The first is a relative threshold. A live path survives only if its metric is strictly above the previous maximum plus a non-positive offset. The second is a cap. If more paths pass the threshold than the configured limit allows, only the highest-metric ones are kept, and ties go to the lower state index. The unit also returns the largest surviving metric, which the decoder feeds back as the reference for the next step. States left out of the mask are expected to come back with their active flag cleared. The offset and the cap are registers that can be written only while no step is in flight.

The unit accepts one step per cycle. It returns the matching mask two cycles later, together with a valid strobe.

Top module: `path_prune`

## Requirements
- R1: After reset, `out_valid` and `out_keep` are 0, the threshold register holds -2 and the cap register holds 3.
- R2: A state can be kept only if its metric, read as a signed two's complement value, is strictly greater than `in_prev_max` plus the threshold. A metric equal to that sum is discarded.
- R3: A state whose `in_active` bit is 0 is never kept, whatever its metric.
- R4: The number of set bits in `out_keep` never exceeds the cap register, and is at least 1 whenever some state passes the threshold.
- R5: When more states pass the threshold than the cap allows, the kept ones are those with the highest metrics.
- R6: Equal metrics at the cap boundary are resolved in favour of the lower state index (bit i of `out_keep` and slice i of `in_metric` belong to state i).
- R7: `out_valid` is high exactly two cycles after `in_valid` was sampled high, and `out_keep`/`out_max` belong to that step.
- R8: `out_max` equals the largest metric among the kept states. If no state is kept, it equals the `in_prev_max` of that step.
- R9: A configuration write (`cfg_we`) takes effect only when `in_valid` is low in that cycle and no step is in the first pipeline stage. Otherwise the write is ignored and both registers keep their values.
- R10: A written threshold above 0 is stored as 0. A written cap of 0 is stored as 1, and a written cap above `NS` is stored as `NS`.
- R11: Steps may arrive on consecutive cycles, and each produces its own result without interference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_thr | input | MW | Threshold offset, signed |
| cfg_cap | input | $clog2(NS+1) | Maximum surviving paths |
| in_valid | input | 1 | Step input valid |
| in_metric | input | NS*MW | Signed state metrics, state i in bits [i*MW +: MW] |
| in_active | input | NS | Live-path flag per state |
| in_prev_max | input | MW | Previous stage maximum metric, signed |
| out_valid | output | 1 | Result valid |
| out_keep | output | NS | Surviving-path mask |
| out_max | output | MW | Largest surviving metric, signed |

## Verification
The assertions check on every cycle that the mask never exceeds the cap and is never empty when some path passed the threshold. They also check that it never includes an inactive state, that the valid strobe trails the input by two cycles, that the stored threshold stays non-positive, that the cap stays in range, and that the registers hold still while a step is in flight. Which states are kept, the strict boundary of the threshold, the ordering under ties, the reported maximum, and the clamping and ignoring of configuration writes can only be shown by the bench's scenarios. The bench compares those results against a behavioural model on every cycle.

// File: rtl/path_prune.sv
module path_prune #(
  parameter int NS = 8,
  parameter int MW = 12,
  localparam int CW = $clog2(NS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [MW-1:0]        cfg_thr,
  input  logic [CW-1:0]        cfg_cap,
  input  logic                 in_valid,
  input  logic [NS*MW-1:0]     in_metric,
  input  logic [NS-1:0]        in_active,
  input  logic [MW-1:0]        in_prev_max,
  output logic                 out_valid,
  output logic [NS-1:0]        out_keep,
  output logic [MW-1:0]        out_max
);

  logic signed [MW-1:0] thr_q;
  logic [CW-1:0]        cap_q;

  logic                 v1;
  logic [NS-1:0]        pass1;
  logic signed [MW-1:0] met1 [NS];
  logic signed [MW-1:0] pm1;

  // configuration, accepted only while idle
  wire cfg_ok = cfg_we & ~in_valid & ~v1;
  wire signed [MW-1:0] thr_in = $signed(cfg_thr);
  wire signed [MW-1:0] thr_clamped = (thr_in > 0) ? '0 : thr_in;
  wire [CW-1:0] cap_clamped = (cfg_cap == '0) ? CW'(1) :
                              (cfg_cap > CW'(NS)) ? CW'(NS) : cfg_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= -MW'(2);
      cap_q <= CW'(3);
    end else if (cfg_ok) begin
      thr_q <= thr_clamped;
      cap_q <= cap_clamped;
    end
  end

  // stage 1: threshold test against previous maximum
  wire signed [MW:0] limit = $signed({in_prev_max[MW-1], in_prev_max}) +
                             $signed({thr_q[MW-1], thr_q});
  logic [NS-1:0] pass_c;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      logic signed [MW:0] m;
      m = $signed({in_metric[i*MW+MW-1], in_metric[i*MW +: MW]});
      pass_c[i] = in_active[i] && (m > limit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      pass1 <= '0;
      pm1   <= '0;
      for (int i = 0; i < NS; i++) met1[i] <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        pass1 <= pass_c;
        pm1   <= $signed(in_prev_max);
        for (int i = 0; i < NS; i++) met1[i] <= $signed(in_metric[i*MW +: MW]);
      end
    end
  end

  // stage 2: rank survivors, keep the best cap_q
  logic [CW-1:0]        rank_c [NS];
  logic [NS-1:0]        keep_c;
  logic signed [MW-1:0] max_c;
  logic                 any_c;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      rank_c[i] = '0;
      for (int j = 0; j < NS; j++) begin
        if (j != i && pass1[j] &&
            ((met1[j] > met1[i]) || ((met1[j] == met1[i]) && (j < i))))
          rank_c[i] = rank_c[i] + CW'(1);
      end
      keep_c[i] = pass1[i] && (rank_c[i] < cap_q);
    end
  end

  always_comb begin
    max_c = pm1;
    any_c = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (keep_c[i] && (!any_c || met1[i] > max_c)) begin
        max_c = met1[i];
        any_c = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_keep  <= '0;
      out_max   <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        out_keep <= keep_c;
        out_max  <= max_c;
      end
    end
  end

  AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_keep) <= int'(cap_q)));                 // R4
  AST_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && pass1 != '0) |=> (out_keep != '0));                            // R4
  AST_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_keep & ~$past(in_active, 2)) == '0));             // R3
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |=> out_valid);                                        // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |=> !out_valid);                                      // R7
  AST_THR_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q <= 0);                                                           // R10
  AST_CAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q >= CW'(1)) && (cap_q <= CW'(NS)));                              // R10
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid || v1) |=> ($stable(thr_q) && $stable(cap_q)));             // R9

endmodule

// File: tb/path_prune_bench.sv
module path_prune_bench;
  localparam int NS = 8;
  localparam int MW = 12;
  localparam int CW = $clog2(NS + 1);

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic cfg_we = 0, in_valid = 0;
  logic [MW-1:0] cfg_thr = '0, in_prev_max = '0;
  logic [CW-1:0] cfg_cap = '0;
  logic [NS*MW-1:0] in_metric = '0;
  logic [NS-1:0] in_active = '0;
  logic out_valid;
  logic [NS-1:0] out_keep;
  logic signed [MW-1:0] out_max;

  path_prune #(.NS(NS), .MW(MW)) u_path_prune (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thr(cfg_thr),
    .cfg_cap(cfg_cap), .in_valid(in_valid), .in_metric(in_metric),
    .in_active(in_active), .in_prev_max(in_prev_max), .out_valid(out_valid),
    .out_keep(out_keep), .out_max(out_max));

  int checks = 0, errors = 0;
  bit done = 0;

  // model configuration
  int m_thr = -2, m_cap = 3;
  // model pipeline
  bit p1_v = 0, p2_v = 0;
  bit [NS-1:0] p1_k, p2_k;
  int p1_m, p2_m;
  string p1_t = "", p2_t = "";

  // next drive values
  bit nx_we = 0, nx_iv = 0;
  int nx_thr = 0, nx_cap = 0, nx_pm = 0;
  int nx_met [NS];
  bit [NS-1:0] nx_act = '0;
  string tag = "R11";

  function automatic void check(bit ok, string t, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endfunction

  task automatic tick();
    bit [NS-1:0] k;
    int mx;
    bit any;
    @(negedge clk);
    check(out_valid == p2_v, "R7", "out_valid", out_valid, p2_v);
    if (p2_v) begin
      check(out_keep == p2_k, p2_t, "out_keep", out_keep, p2_k);
      check(int'(out_max) == p2_m, "R8", "out_max", out_max, p2_m);
    end
    // model the step being driven now
    k = '0; mx = nx_pm; any = 0;
    for (int i = 0; i < NS; i++) begin
      int rk = 0;
      bit pi = nx_act[i] && (nx_met[i] > nx_pm + m_thr);
      if (!pi) continue;
      for (int j = 0; j < NS; j++) begin
        bit pj = nx_act[j] && (nx_met[j] > nx_pm + m_thr);
        if (j != i && pj && (nx_met[j] > nx_met[i] || (nx_met[j] == nx_met[i] && j < i)))
          rk++;
      end
      if (rk < m_cap) begin
        k[i] = 1;
        if (!any || nx_met[i] > mx) mx = nx_met[i];
        any = 1;
      end
    end
    if (nx_we && !nx_iv && !p1_v) begin
      m_thr = (nx_thr > 0) ? 0 : nx_thr;
      m_cap = (nx_cap < 1) ? 1 : (nx_cap > NS) ? NS : nx_cap;
    end
    p2_v = p1_v; p2_k = p1_k; p2_m = p1_m; p2_t = p1_t;
    p1_v = nx_iv; p1_k = k; p1_m = mx; p1_t = tag;
    cfg_we = nx_we; cfg_thr = MW'(nx_thr); cfg_cap = CW'(nx_cap);
    in_valid = nx_iv; in_prev_max = MW'(nx_pm); in_active = nx_act;
    for (int i = 0; i < NS; i++) in_metric[i*MW +: MW] = MW'(nx_met[i]);
  endtask

  task automatic idle(int n);
    nx_we = 0; nx_iv = 0;
    repeat (n) tick();
  endtask

  task automatic cfg(int thr, int cap);
    nx_we = 1; nx_iv = 0; nx_thr = thr; nx_cap = cap;
    tick();
    nx_we = 0;
    idle(1);
  endtask

  task automatic step(int pm, bit [NS-1:0] act, int m0, int m1, int m2, int m3,
                      int m4, int m5, int m6, int m7);
    nx_iv = 1; nx_pm = pm; nx_act = act;
    nx_met[0] = m0; nx_met[1] = m1; nx_met[2] = m2; nx_met[3] = m3;
    nx_met[4] = m4; nx_met[5] = m5; nx_met[6] = m6; nx_met[7] = m7;
    tick();
    nx_iv = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) nx_met[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    check(out_keep == 0, "R1", "out_keep in reset", out_keep, 0);
    rst_n = 1;
    idle(2);
    // R1/R5: defaults T=-2, cap 3 -> keep states 2,4,5
    tag = "R5";
    step(10, 8'hFF, 9, 8, 11, 7, 12, 10, 3, 9);
    idle(2);
    check(p2_k == 8'b0011_0100, "R1", "model default mask", p2_k, 8'b0011_0100);
    // R2: strict boundary with T=0
    cfg(0, 8);
    tag = "R2";
    step(5, 8'hFF, 5, 6, 5, 4, -3, 6, 5, 7);
    step(-20, 8'hFF, -20, -19, -21, -20, 100, -2048, -20, -19);
    idle(2);
    // R3: inactive states never kept
    tag = "R3";
    step(0, 8'b0101_0101, 50, 60, 50, 60, 50, 60, 50, 60);
    step(0, 8'h00, 50, 60, 50, 60, 50, 60, 50, 60);
    idle(2);
    // R6: ties at the cap boundary
    cfg(-4, 3);
    tag = "R6";
    step(0, 8'hFF, 7, 7, 7, 7, 7, 7, 7, 7);
    step(0, 8'hFF, 1, 9, 5, 5, 5, 9, 5, 0);
    idle(2);
    // R8: nothing passes -> out_max = prev max
    tag = "R8";
    step(40, 8'hFF, 1, 2, 3, 4, 5, 6, 36, 35);
    idle(2);
    // R10: clamping of configuration
    tag = "R10";
    cfg(5, 0);
    step(3, 8'hFF, 3, 4, 9, 3, 8, 2, 4, 9);
    idle(2);
    cfg(-100, 15);
    step(3, 8'hFF, 3, 4, 9, 3, 8, 2, 4, 9);
    idle(2);
    // R9: writes while busy are ignored
    cfg(-2, 2);
    tag = "R9";
    nx_we = 1; nx_thr = -50; nx_cap = 8;
    step(0, 8'hFF, 1, 2, 3, 4, 5, 6, 7, 8);
    nx_we = 1; nx_iv = 0; tick();   // stage 1 busy: ignored
    nx_we = 0;
    step(0, 8'hFF, -1, 2, 3, 4, 5, 6, 7, 8);
    idle(2);
    // R4/R11: back-to-back random steps
    tag = "R11";
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 49) begin
        cfg(-int'($urandom_range(0, 40)), int'($urandom_range(0, 12)));
      end
      nx_iv = ($urandom_range(0, 7) != 0);
      nx_we = ($urandom_range(0, 9) == 0);
      nx_thr = int'($urandom_range(0, 60)) - 40;
      nx_cap = int'($urandom_range(0, 15));
      nx_pm = int'($urandom_range(0, 200)) - 100;
      nx_act = NS'($urandom);
      for (int i = 0; i < NS; i++) nx_met[i] = nx_pm + int'($urandom_range(0, 40)) - 30;
      tag = (n % 2 == 0) ? "R4" : "R11";
      tick();
    end
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule